// File: doc/BRIEF.md
# PCI Configuration Cycle Translator

This block sits inside a host-to-PCI bridge and turns a processor access to an outbound window into a PCI transaction descriptor. Software programs a 32-bit configuration address register that names a target bus, device, function and dword register, and that carries an enable bit. When an access lands in a window marked as I/O space, the block uses that register to choose the transaction. It can issue a Type 0 configuration cycle to the local bus, a Type 1 configuration cycle to a remote bus, an interrupt-acknowledge or special cycle, or a plain I/O transaction.

Each accepted request produces one descriptor. The descriptor holds the address-phase AD value, the bus command, the active-low data byte enables and a kind code. It is offered on a valid/ready handshake and is held until the consumer takes it. A small two-state machine controls this. In ST_IDLE the block is ready for a request. Accepting a request (transition ACCEPT) moves it to ST_HOLD. In ST_HOLD the descriptor is valid. When the consumer takes the descriptor (transition DRAIN), the block returns to ST_IDLE.

Top module: `cfg_xlate_top`

## Requirements
- R1: During reset, reg_rdata is 0, out_valid is 0 and req_ready is 1.
- R2: A register write takes effect on the clock edge that samples reg_wr. Field layout: enable at bit 31, bus at [23:16], device at [15:11], function at [10:8], register number at [7:2]. Bits [30:24] and [1:0] always read as 0.
- R3: A request accepted in the same cycle as a register write is translated with the register value from before that write.
- R4: An access with req_is_io=0 gives kind 0 (memory), command 4'h6 for a read or 4'h7 for a write, and out_ad equal to req_addr, whatever the register holds.
- R5: An I/O access with the enable bit clear gives kind 1, command 4'h2 for a read or 4'h3 for a write, and out_ad equal to req_addr.
- R6: An I/O access with enable set, a device number other than 31 and bus 0 gives kind 2 (Type 0). Its command is 4'hA for a read or 4'hB for a write. out_ad has bit 11+device set when device ≤ 20, and bits [31:11] are all zero for devices 21 to 30. The function goes to out_ad[10:8], the register number to out_ad[7:2], and out_ad[1:0] is 0.
- R7: An I/O access with enable set, a device number other than 31 and a non-zero bus gives kind 3 (Type 1). Its command is 4'hA or 4'hB. out_ad[31:24] is 0, out_ad[23:2] copies bus, device, function and register, and out_ad[1:0] is 2'b01.
- R8: An I/O access with enable set and device 31 gives kind 4. A read gives command 4'h0 (interrupt acknowledge) and a write gives 4'h1 (special cycle). out_ad equals req_addr.
- R9: out_be_n is active low. req_size 0 (1 byte) enables byte req_addr[1:0]. req_size 1 (2 bytes) enables bytes 1:0 when req_addr[1]=0 and bytes 3:2 otherwise. req_size 2 or 3 (4 bytes) enables all four bytes.
- R10: req_ready is high only while no descriptor is held. A held descriptor keeps out_valid high and all of its fields stable until out_ready is sampled high. A request offered while a descriptor is held is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Configuration address register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| req_valid | input | 1 | Window access request |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Window-translated access address |
| req_size | input | 2 | Access size: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_is_io | input | 1 | Window is programmed as I/O space |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor consumed |
| out_kind | output | 3 | 0 memory, 1 I/O, 2 Type 0, 3 Type 1, 4 intack/special |
| out_ad | output | 32 | Address-phase AD value |
| out_cmd | output | 4 | PCI bus command |
| out_be_n | output | 4 | Active-low byte enables |

## Verification
The hardest case to reach from the ports is a register write and a request in the same cycle, which must be translated with the old register contents. The bench first loads a Type 0 setting. It then raises reg_wr with a disabling value in the same cycle that a request is offered. It checks both that the descriptor is still a configuration cycle and that the new value is readable one edge later. Back-pressure is reached by holding out_ready low while offering a second, different request. The descriptor and the rejected request are then compared over several cycles.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
    localparam int AD_W     = 32;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int REGN_W   = 6;
    localparam int BE_W     = AD_W / 8;
    localparam int EN_POS   = 31;
    localparam int BUS_LO   = 16;
    localparam int DEV_LO   = 11;
    localparam int FN_LO    = 8;
    localparam int REGN_LO  = 2;
    localparam int IDSEL_LO = DEV_LO;
    localparam int IDSEL_W  = AD_W - IDSEL_LO;
    localparam logic [DEV_W-1:0] DEV_RSVD = '1;

    localparam logic [3:0] CMD_INTACK  = 4'h0;
    localparam logic [3:0] CMD_SPECIAL = 4'h1;
    localparam logic [3:0] CMD_IO_RD   = 4'h2;
    localparam logic [3:0] CMD_IO_WR   = 4'h3;
    localparam logic [3:0] CMD_MEM_RD  = 4'h6;
    localparam logic [3:0] CMD_MEM_WR  = 4'h7;
    localparam logic [3:0] CMD_CFG_RD  = 4'hA;
    localparam logic [3:0] CMD_CFG_WR  = 4'hB;

    typedef enum logic [2:0] {
        KIND_MEM  = 3'd0,
        KIND_IO   = 3'd1,
        KIND_CFG0 = 3'd2,
        KIND_CFG1 = 3'd3,
        KIND_SPEC = 3'd4
    } xact_kind_e;

    typedef struct packed {
        logic              en;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [REGN_W-1:0] regn;
    } cfg_addr_t;

    typedef struct packed {
        xact_kind_e       kind;
        logic [AD_W-1:0]  ad;
        logic [3:0]       cmd;
        logic [BE_W-1:0]  be_n;
    } xact_t;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_xlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AD_W-1:0] wdata,
    output cfg_addr_t       q,
    output logic [AD_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q.en   <= wdata[EN_POS];
            q.bus  <= wdata[BUS_LO  +: BUS_W];
            q.dev  <= wdata[DEV_LO  +: DEV_W];
            q.fn   <= wdata[FN_LO   +: FN_W];
            q.regn <= wdata[REGN_LO +: REGN_W];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[EN_POS]             = q.en;
        rdata[BUS_LO  +: BUS_W]   = q.bus;
        rdata[DEV_LO  +: DEV_W]   = q.dev;
        rdata[FN_LO   +: FN_W]    = q.fn;
        rdata[REGN_LO +: REGN_W]  = q.regn;
    end
endmodule

// File: rtl/cfg_byte_en.sv
module cfg_byte_en
    import cfg_xlate_pkg::*;
(
    input  logic [1:0]      addr_lo,
    input  logic [1:0]      size,
    output logic [BE_W-1:0] be_n
);
    logic [BE_W-1:0] be;

    always_comb begin
        unique case (size)
            2'd0:    be = BE_W'(1) << addr_lo;
            2'd1:    be = addr_lo[1] ? 4'b1100 : 4'b0011;
            default: be = '1;
        endcase
        be_n = ~be;
    end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_xlate_pkg::*;
(
    input  cfg_addr_t       car,
    input  logic [AD_W-1:0] addr,
    input  logic [1:0]      size,
    input  logic            write,
    input  logic            is_io,
    output xact_t           xact
);
    logic [IDSEL_W-1:0] idsel;
    logic [BE_W-1:0]    be_n;

    for (genvar g = 0; g < IDSEL_W; g++) begin : g_idsel
        assign idsel[g] = (car.dev == DEV_W'(g));
    end

    cfg_byte_en u_be (
        .addr_lo (addr[1:0]),
        .size    (size),
        .be_n    (be_n)
    );

    always_comb begin
        xact.ad   = addr;
        xact.be_n = be_n;
        xact.kind = KIND_MEM;
        xact.cmd  = write ? CMD_MEM_WR : CMD_MEM_RD;
        if (is_io) begin
            if (!car.en) begin
                xact.kind = KIND_IO;
                xact.cmd  = write ? CMD_IO_WR : CMD_IO_RD;
            end else if (car.dev == DEV_RSVD) begin
                xact.kind = KIND_SPEC;
                xact.cmd  = write ? CMD_SPECIAL : CMD_INTACK;
            end else if (car.bus == '0) begin
                xact.kind = KIND_CFG0;
                xact.cmd  = write ? CMD_CFG_WR : CMD_CFG_RD;
                xact.ad   = {idsel, car.fn, car.regn, 2'b00};
            end else begin
                xact.kind = KIND_CFG1;
                xact.cmd  = write ? CMD_CFG_WR : CMD_CFG_RD;
                xact.ad   = {{(AD_W-BUS_LO-BUS_W){1'b0}}, car.bus, car.dev,
                             car.fn, car.regn, 2'b01};
            end
        end
    end
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
    import cfg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_write,
    input  logic        req_is_io,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [2:0]  out_kind,
    output logic [31:0] out_ad,
    output logic [3:0]  out_cmd,
    output logic [3:0]  out_be_n
);
    typedef enum logic {ST_IDLE, ST_HOLD} state_e;

    state_e    state_q, state_d;
    cfg_addr_t car_q;
    xact_t     xact_d, xact_q;

    cfg_addr_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .q     (car_q),
        .rdata (reg_rdata)
    );

    cfg_decode u_dec (
        .car   (car_q),
        .addr  (req_addr),
        .size  (req_size),
        .write (req_write),
        .is_io (req_is_io),
        .xact  (xact_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xact_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            xact_q <= xact_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_HOLD: out_valid = 1'b1;
        endcase
        out_kind = xact_q.kind;
        out_ad   = xact_q.ad;
        out_cmd  = xact_q.cmd;
        out_be_n = xact_q.be_n;
    end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [2:0]  out_kind,
    input logic [31:0] out_ad,
    input logic [3:0]  out_cmd,
    input logic [3:0]  out_be_n
);
    localparam logic [31:0] RD_MASK = 32'h80FF_FFFC;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ad) &&
        $stable(out_cmd) && $stable(out_be_n) && $stable(out_kind));

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && out_valid));

    // R2
    reg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata == ($past(reg_wdata) & RD_MASK));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~RD_MASK) == 32'h0);

    // R6
    type0_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd2 |-> out_ad[1:0] == 2'b00 &&
        $onehot0(out_ad[31:11]) && (out_cmd == 4'hA || out_cmd == 4'hB));

    // R7
    type1_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd3 |-> out_ad[1:0] == 2'b01 &&
        out_ad[31:24] == 8'h00 && (out_cmd == 4'hA || out_cmd == 4'hB));

    // R4
    mem_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd0 |-> out_cmd == 4'h6 || out_cmd == 4'h7);

    // R9
    be_some_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(~out_be_n) != 0);
endmodule

bind cfg_xlate_top cfg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_ad    (out_ad),
    .out_cmd   (out_cmd),
    .out_be_n  (out_be_n)
);

// File: tb/sim_cfg_xlate_top.sv
module sim_cfg_xlate_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic [31:0] regv;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic        io;
        logic [2:0]  kind;
        logic [31:0] ad;
        logic [3:0]  cmd;
        logic [3:0]  be_n;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{32'h0000_0000, 32'h0000_1004, 2'd2, 1'b0, 1'b1, 3'd1, 32'h0000_1004, 4'h2, 4'h0},
        '{32'h8000_1140, 32'h0000_0000, 2'd2, 1'b0, 1'b1, 3'd2, 32'h0000_2140, 4'hA, 4'h0},
        '{32'h8000_1140, 32'h0000_0002, 2'd0, 1'b1, 1'b1, 3'd2, 32'h0000_2140, 4'hB, 4'hB},
        '{32'h8005_1A3C, 32'h0000_0002, 2'd1, 1'b0, 1'b1, 3'd3, 32'h0005_1A3D, 4'hA, 4'h3},
        '{32'h8005_1A3C, 32'h0000_0000, 2'd1, 1'b1, 1'b1, 3'd3, 32'h0005_1A3D, 4'hB, 4'hC},
        '{32'h8000_F800, 32'h0000_0ABC, 2'd2, 1'b0, 1'b1, 3'd4, 32'h0000_0ABC, 4'h0, 4'h0},
        '{32'h8000_F800, 32'h0000_0010, 2'd0, 1'b1, 1'b1, 3'd4, 32'h0000_0010, 4'h1, 4'hE},
        '{32'h8000_1140, 32'h4000_0000, 2'd2, 1'b0, 1'b0, 3'd0, 32'h4000_0000, 4'h6, 4'h0},
        '{32'h8000_1140, 32'h4000_0003, 2'd0, 1'b1, 1'b0, 3'd0, 32'h4000_0003, 4'h7, 4'h7},
        '{32'h8000_A800, 32'h0000_0000, 2'd2, 1'b0, 1'b1, 3'd2, 32'h0000_0000, 4'hA, 4'h0},
        '{32'h8000_A000, 32'h0000_0000, 2'd3, 1'b0, 1'b1, 3'd2, 32'h8000_0000, 4'hA, 4'h0},
        '{32'h0005_F800, 32'h0000_0FFC, 2'd2, 1'b1, 1'b1, 3'd1, 32'h0000_0FFC, 4'h3, 4'h0},
        '{32'h8000_07FC, 32'h0000_0000, 2'd2, 1'b0, 1'b1, 3'd2, 32'h0000_0FFC, 4'hA, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_is_io = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_kind;
    logic [31:0] out_ad;
    logic [3:0]  out_cmd;
    logic [3:0]  out_be_n;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_xlate_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_is_io(req_is_io), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_ad(out_ad), .out_cmd(out_cmd), .out_be_n(out_be_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k);
        case (k)
            3'd0:    return "R4";
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic offer(input logic [31:0] a, input logic [1:0] s,
                         input logic w, input logic io);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_size = s;
        req_write = w;
        req_is_io = io;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 out_valid", {31'b0, out_valid}, 32'h0);
        chk("R1 req_ready", {31'b0, req_ready}, 32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            write_reg(TBL[i].regv);
            offer(TBL[i].addr, TBL[i].size, TBL[i].wr, TBL[i].io);
            chk("R10 valid", {31'b0, out_valid}, 32'h1);
            chk(kind_tag(TBL[i].kind), {29'b0, out_kind}, {29'b0, TBL[i].kind});
            chk(kind_tag(TBL[i].kind), out_ad, TBL[i].ad);
            chk(kind_tag(TBL[i].kind), {28'b0, out_cmd}, {28'b0, TBL[i].cmd});
            chk("R9 be_n", {28'b0, out_be_n}, {28'b0, TBL[i].be_n});
            drain();
        end

        // R2: write lands on the sampling edge, reserved bits read zero
        write_reg(32'h0000_0000);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 32'hFFFF_FFFF;
        chk("R2 before edge", reg_rdata, 32'h0);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R2 after edge", reg_rdata, 32'h80FF_FFFC);

        // R3: request and register write in the same cycle
        write_reg(32'h8000_1140);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 32'h0000_0000;
        req_valid = 1'b1;
        req_addr = 32'h0;
        req_size = 2'd2;
        req_write = 1'b0;
        req_is_io = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        req_valid = 1'b0;
        chk("R3 kind", {29'b0, out_kind}, 32'd2);
        chk("R3 ad", out_ad, 32'h0000_2140);
        chk("R2 new value", reg_rdata, 32'h0);
        drain();

        // R10: back-pressure holds the descriptor, a second request is refused
        offer(32'h0000_0100, 2'd2, 1'b0, 1'b1);
        req_valid = 1'b1;
        req_addr = 32'h0000_0200;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 held valid", {31'b0, out_valid}, 32'h1);
            chk("R10 ready low", {31'b0, req_ready}, 32'h0);
            chk("R10 held ad", out_ad, 32'h0000_0100);
        end
        req_valid = 1'b0;
        drain();
        chk("R10 drained", {31'b0, out_valid}, 32'h0);
        chk("R10 ready back", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        chk("R10 no stray accept", {31'b0, out_valid}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule